// File: doc/BRIEF.md
# Live-Update Pulse-Width Modulator Channel

This block drives one pulse-width modulated output from two 24-bit settings: a period length and an on-time (duty), both counted in ticks. The counter advances on each tick. The output is at its active level while the count is below the duty value.

Software can rewrite either setting while the channel runs. Each write lands in a holding (shadow) register. The shadow is copied to the working register only when the counter wraps, so a period already under way always finishes with the values it started with. The same copy happens on every cycle while the channel is disabled.

Duty settings of zero and of the full period give exact 0% and 100% outputs. A polarity input inverts the output. A select input picks the count rate:
- one tick per system clock, or
- one tick every 50 system clocks, taken from an enable-pulse prescaler.

Top module: `pwm_dual_reg_top`

## Requirements
- R1: After reset with the channel disabled, both working registers hold zero and the output sits at the inactive level: 0 when `pol_i`=0, 1 when `pol_i`=1.
- R2: With working period P, one PWM period lasts P ticks, with the count running 0 to P-1. A P of 0 or 1 gives a period of one tick.
- R3: While enabled, the output is active during the first D ticks of each period (count < D), where D is the working duty.
- R4: A working duty of 0 keeps the output inactive for the whole period.
- R5: A working duty greater than or equal to the working period keeps the output active for the whole period.
- R6: `pol_i`=0 makes the active level 1. `pol_i`=1 inverts the output, so the active level is 0 and the inactive level is 1.
- R7: A period or duty write made while the channel runs takes effect at the start of the next period. The period under way completes with the old values.
- R8: `clk_sel_i`=0 gives one tick per clock. `clk_sel_i`=1 gives one tick every 50 clocks, with the first tick on the 50th clock edge after enabling.
- R9: Clearing `en_i` drives the output to the inactive level at once and holds the count at 0. While disabled, the working registers follow the shadows. On re-enable, a period starts from count 0 with the latest written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Channel run enable |
| pol_i | input | 1 | Output polarity, 1 inverts |
| clk_sel_i | input | 1 | Tick rate: 0 every clock, 1 every 50 clocks |
| period_we_i | input | 1 | Write strobe for the period shadow |
| period_wdata_i | input | 24 | Period value to write |
| duty_we_i | input | 1 | Write strobe for the duty shadow |
| duty_wdata_i | input | 24 | Duty value to write |
| pwm_o | output | 1 | Modulated output |

## Verification
The checks take for granted that `pol_i` and `clk_sel_i` change only while the channel is disabled. A polarity flip mid-period would legitimately move the output, and a rate change would shift tick timing.

The checks also take for granted that write strobes are single-cycle pulses with stable data. The counter bound assumes the working period changes only at a wrap or while disabled.

The stimulus keeps within these assumptions:
- every polarity and rate change is made with `en_i` low;
- every write is a one-clock pulse driven at the falling edge;
- live rewrites are issued mid-period, so that the old and new values can be told apart at the boundary.

// File: rtl/pwm_pkg.sv
// Package: shared types for the PWM channel.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_pkg;

    // Count-rate choice for the period counter
    typedef enum logic {
        TICK_EVERY_CLK = 1'b0,
        TICK_DIVIDED   = 1'b1
    } tick_sel_e;

endpackage

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Produces a one-cycle enable pulse every DIV clocks while run_i is high.
// Assumes: DIV >= 1; the count restarts from zero whenever run_i is low,
// so the first pulse comes on the DIV-th edge after run_i rises.
module pwm_prescaler #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    // Divider count: cleared when idle, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = run_i && (div_q == LAST);
endmodule

// File: rtl/pwm_shadow.sv
// Module: pwm_shadow
// Holds a written value in a shadow register and copies it to the working
// register when load_i is high.
// Assumes: load_i is only asserted at a period boundary or while idle.
module pwm_shadow #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         load_i,
    output logic [W-1:0] act_o
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] act_q;

    // Shadow capture on every write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (we_i) begin
            shadow_q <= wdata_i;
        end
    end

    // Working copy updated only on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (load_i) begin
            act_q <= shadow_q;
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// Period counter running 0..period-1 on ticks; flags the last count.
// Assumes: a period of 0 or 1 is treated as a single-tick period.
module pwm_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] period_i,
    output logic         last_o,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    assign last_o = (period_i <= ONE) || (cnt_q == period_i - ONE);

    // Count advance: held at zero when idle, wraps on the last count
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= last_o ? '0 : cnt_q + ONE;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_dual_reg_top.sv
// Module: pwm_dual_reg_top
// One PWM channel with shadowed period and duty, selectable tick rate,
// programmable polarity and a run enable.
// Assumes: pol_i and clk_sel_i are changed only while en_i is low.
module pwm_dual_reg_top #(
    parameter int CNT_W     = 24,
    parameter int SLOW_DIV  = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             pol_i,
    input  logic             clk_sel_i,
    input  logic             period_we_i,
    input  logic [CNT_W-1:0] period_wdata_i,
    input  logic             duty_we_i,
    input  logic [CNT_W-1:0] duty_wdata_i,
    output logic             pwm_o
);
    import pwm_pkg::*;

    tick_sel_e        rate_sel;
    logic             slow_tick;
    logic             tick;
    logic             last_cnt;
    logic             load;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_act;
    logic [CNT_W-1:0] duty_act;
    logic             on_phase;

    assign rate_sel = tick_sel_e'(clk_sel_i);

    pwm_prescaler #(.DIV(SLOW_DIV)) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (en_i),
        .tick_o (slow_tick)
    );

    // Tick source choice
    always_comb begin
        tick = (rate_sel == TICK_DIVIDED) ? slow_tick : 1'b1;
    end

    // Working registers reload at a wrap or continuously while idle
    assign load = !en_i || (tick && last_cnt);

    pwm_shadow #(.W(CNT_W)) period_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (period_we_i),
        .wdata_i (period_wdata_i),
        .load_i  (load),
        .act_o   (period_act)
    );

    pwm_shadow #(.W(CNT_W)) duty_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (duty_we_i),
        .wdata_i (duty_wdata_i),
        .load_i  (load),
        .act_o   (duty_act)
    );

    pwm_counter #(.W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (en_i),
        .tick_i   (tick),
        .period_i (period_act),
        .last_o   (last_cnt),
        .cnt_o    (cnt_q)
    );

    // Compare stage and polarity
    always_comb begin
        on_phase = en_i && (cnt_q < duty_act);
        pwm_o    = on_phase ^ pol_i;
    end
endmodule

// File: rtl/pwm_dual_reg_chk.sv
// Module: pwm_dual_reg_chk
// Checker bound into pwm_dual_reg_top.
// Assumes: polarity is stable while the channel is enabled.
module pwm_dual_reg_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_i,
    input logic         pol_i,
    input logic         pwm_o,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] period_act,
    input logic [W-1:0] duty_act
);
    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && period_act > W'(1)) |-> (cnt_q < period_act));

    // R4
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && duty_act == '0) |-> (pwm_o == pol_i));

    // R5
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && duty_act != '0 && duty_act >= period_act) |-> (pwm_o != pol_i));

    // R7
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cnt_q != '0) |-> ($stable(period_act) && $stable(duty_act)));

    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (pwm_o == pol_i));
endmodule

bind pwm_dual_reg_top pwm_dual_reg_chk #(.W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .pol_i      (pol_i),
    .pwm_o      (pwm_o),
    .cnt_q      (cnt_q),
    .period_act (period_act),
    .duty_act   (duty_act)
);

// File: tb/pwm_dual_reg_top_tb.sv
// Bench: pwm_dual_reg_top_tb_top
// Table-driven sweep of period, duty and polarity,
// then directed tests for reset, live update, disable and the slow rate.
module pwm_dual_reg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        pol_i = 1'b0;
    logic        clk_sel_i = 1'b0;
    logic        period_we_i = 1'b0;
    logic [23:0] period_wdata_i = '0;
    logic        duty_we_i = 1'b0;
    logic [23:0] duty_wdata_i = '0;
    logic        pwm_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwm_dual_reg_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (en_i),
        .pol_i          (pol_i),
        .clk_sel_i      (clk_sel_i),
        .period_we_i    (period_we_i),
        .period_wdata_i (period_wdata_i),
        .duty_we_i      (duty_we_i),
        .duty_wdata_i   (duty_wdata_i),
        .pwm_o          (pwm_o)
    );

    // {pol, period, duty}: R3 R4 R5 R6 R2 cases
    localparam logic [48:0] VEC [8] = '{
        {1'b0, 24'd10, 24'd3},
        {1'b0, 24'd10, 24'd0},
        {1'b0, 24'd10, 24'd10},
        {1'b1, 24'd10, 24'd15},
        {1'b1, 24'd1,  24'd1},
        {1'b0, 24'd1,  24'd0},
        {1'b0, 24'd0,  24'd5},
        {1'b1, 24'd7,  24'd6}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_on(input int k, input int p, input int d);
        int pe;
        pe = (p <= 1) ? 1 : p;
        return (k % pe) < d;
    endfunction

    // Write both shadows with en low, let them reach the working registers
    task automatic load_idle(input int p, input int d);
        @(negedge clk);
        en_i = 1'b0;
        period_wdata_i = 24'(p);
        duty_wdata_i = 24'(d);
        period_we_i = 1'b1;
        duty_we_i = 1'b1;
        @(negedge clk);
        period_we_i = 1'b0;
        duty_we_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(pwm_o == 1'b0, "R1", pwm_o, 0);
        pol_i = 1'b1;
        #1;
        check(pwm_o == 1'b1, "R6", pwm_o, 1);
        pol_i = 1'b0;

        // Table sweep: R2 R3 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            int p;
            int d;
            int bad;
            int first_act;
            int first_exp;
            bit pl;
            pl = VEC[v][48];
            p = int'(VEC[v][47:24]);
            d = int'(VEC[v][23:0]);
            bad = 0;
            first_act = 0;
            first_exp = 0;
            load_idle(p, d);
            pol_i = pl;
            en_i = 1'b1;
            #1;
            for (int k = 0; k < 2 * ((p <= 1) ? 1 : p) + 3; k++) begin
                bit e;
                if (k > 0) begin
                    @(negedge clk);
                    #1;
                end
                e = exp_on(k, p, d) ^ pl;
                if (pwm_o != e && bad == 0) begin
                    first_act = pwm_o;
                    first_exp = e;
                end
                if (pwm_o != e) bad++;
            end
            check(bad == 0, (d == 0) ? "R4" : (d >= p) ? "R5" : pl ? "R6" : "R3",
                  first_act, first_exp);
        end

        // R7 live update: start P=8 D=2, then write D=6 at k=3 and P=4 at k=4
        pol_i = 1'b0;
        load_idle(8, 2);
        en_i = 1'b1;
        #1;
        begin
            int bad7;
            bad7 = 0;
            for (int k = 0; k < 16; k++) begin
                bit e;
                if (k > 0) begin
                    @(negedge clk);
                    #1;
                end
                e = (k < 8) ? (k < 2) : 1'b1;
                if (pwm_o != e) bad7++;
                duty_we_i = 1'b0;
                period_we_i = 1'b0;
                if (k == 3) begin
                    duty_wdata_i = 24'd6;
                    duty_we_i = 1'b1;
                end
                if (k == 4) begin
                    period_wdata_i = 24'd4;
                    period_we_i = 1'b1;
                end
            end
            check(bad7 == 0, "R7", bad7, 0);
        end

        // R9 disable: write D=1 while running, then drop enable
        @(negedge clk);
        duty_wdata_i = 24'd1;
        duty_we_i = 1'b1;
        @(negedge clk);
        duty_we_i = 1'b0;
        en_i = 1'b0;
        #1;
        check(pwm_o == 1'b0, "R9", pwm_o, 0);
        repeat (3) @(negedge clk);
        en_i = 1'b1;
        #1;
        check(pwm_o == 1'b1, "R9", pwm_o, 1);
        @(negedge clk);
        #1;
        check(pwm_o == 1'b0, "R9", pwm_o, 0);
        repeat (3) @(negedge clk);
        #1;
        check(pwm_o == 1'b1, "R2", pwm_o, 1);

        // R8 slow rate: P=2 D=1, one tick per 50 clocks
        load_idle(2, 1);
        clk_sel_i = 1'b1;
        en_i = 1'b1;
        #1;
        for (int k = 0; k <= 100; k++) begin
            if (k > 0) begin
                @(negedge clk);
                #1;
            end
            if (k == 0 || k == 49 || k == 100)
                check(pwm_o == 1'b1, "R8", pwm_o, 1);
            if (k == 50 || k == 99)
                check(pwm_o == 1'b0, "R8", pwm_o, 0);
        end
        en_i = 1'b0;
        clk_sel_i = 1'b0;

        // R1 reset clears working registers even after use
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        en_i = 1'b1;
        #1;
        check(pwm_o == 1'b0, "R1", pwm_o, 0);
        en_i = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule